// File: doc/BRIEF.md
# Rotating priority interrupt resolver

This block is the request-and-priority core of a single eight-line interrupt controller. Raw request lines are captured into a request register. Each line is configured as edge- or level-sensitive. The unmasked pending requests are ranked against the lines currently in service, and ranking starts from a movable rotation base. The block asserts its interrupt output whenever a pending request outranks everything in service. It also presents the winning line number in the same cycle.

A processor-side acknowledge pulse takes the winner. It either marks the line as in service or, in automatic end-of-interrupt operation, leaves the in-service register alone and may advance the rotation base past the taken line. An external command decoder owns the mask, trigger modes and mode bits. That decoder loads the rotation base through a write strobe and releases in-service bits through a clear vector. Bus access and cascading of several controllers stay outside this block.

Top module: `irq_rank_resolver`

## Requirements
- R1: After reset the request, in-service and last-level registers are all zero, the rotation base is 0 and `irq_out` is low.
- R2: For a line whose `trig_level` bit is 0 (edge), the request bit sets one clock after the input rises from low to high. A low input never clears the request bit.
- R3: For a line whose `trig_level` bit is 1 (level), the request bit equals the input level sampled at the previous clock.
- R4: A line's rank is (line − base) mod 8, and rank 0 is the highest. `ack_line` shows the best-ranked pending request whose `mask` bit is 0. A masked request never wins.
- R5: `irq_out` is high only when the best pending rank is strictly better than the best in-service rank. An in-service line of equal or better rank holds it low.
- R6: When `sfnm` is 1 and the block is configured as master, the in-service bit of line 2 (the cascade line) is left out of the in-service ranking.
- R7: `ack` while `irq_out` is high with `auto_eoi` at 0 sets the winner's in-service bit at the next clock.
- R8: `ack` while `irq_out` is high with `auto_eoi` at 1 sets no in-service bit. If `rot_on_aeoi` is also 1, the base becomes (winner + 1) mod 8.
- R9: An acknowledge clears the winner's request bit only if the line is edge-sensitive. A level-sensitive request stays pending.
- R10: `ack` while `irq_out` is low reports line 7. It then sets no in-service bit, clears no request bit and leaves the base unchanged.
- R11: A 1 in `isr_clr` clears that in-service bit at the next clock. If the same bit is set by an acknowledge in that cycle, the set wins.
- R12: `base_wr` loads `base_val` into the rotation base. A rotation by an automatic end-of-interrupt acknowledge in the same cycle takes precedence.
- R13: If an edge line's input rises again in the cycle that line is acknowledged, its request bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Raw request lines |
| mask | input | 8 | 1 masks the line from winning |
| trig_level | input | 8 | 1 = level-sensitive, 0 = edge-sensitive |
| base_wr | input | 1 | Load strobe for the rotation base |
| base_val | input | 3 | Value loaded into the rotation base |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_on_aeoi | input | 1 | Rotate base after an automatic end-of-interrupt |
| sfnm | input | 1 | Special fully nested operation |
| isr_clr | input | 8 | Per-line in-service clear |
| ack | input | 1 | Acknowledge pulse |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_line | output | 3 | Winning line, or 7 when none qualifies |
| irr_q | output | 8 | Request register |
| isr_q | output | 8 | In-service register |
| base_q | output | 3 | Current rotation base |

## Verification
Four kinds of collision are possible within a single cycle. An acknowledge can meet an external in-service clear on the same bit. An automatic end-of-interrupt rotation can meet a base load. A fresh rising edge can arrive on the line being acknowledged. A level-sensitive line can be acknowledged while its input stays high. Each collision is provoked by driving both stimuli in one cycle, away from the clock edge. The registered result is then read from `isr_q`, `base_q` and `irr_q` after the next edge. The values expected there come from the precedence fixed in the requirements: set wins over clear, rotation wins over load, and a new edge wins over the acknowledge clear.

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver #(
  parameter int LINES        = 8,
  parameter int CASCADE_LINE = 2,
  parameter bit IS_MASTER    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         req_in,
  input  logic [LINES-1:0]         mask,
  input  logic [LINES-1:0]         trig_level,
  input  logic                     base_wr,
  input  logic [$clog2(LINES)-1:0] base_val,
  input  logic                     auto_eoi,
  input  logic                     rot_on_aeoi,
  input  logic                     sfnm,
  input  logic [LINES-1:0]         isr_clr,
  input  logic                     ack,
  output logic                     irq_out,
  output logic [$clog2(LINES)-1:0] ack_line,
  output logic [LINES-1:0]         irr_q,
  output logic [LINES-1:0]         isr_q,
  output logic [$clog2(LINES)-1:0] base_q
);
  localparam int RW    = $clog2(LINES);
  localparam int RANKW = RW + 1;
  localparam logic [RW-1:0]    SPUR_LINE = RW'(LINES - 1);
  localparam logic [RANKW-1:0] NO_RANK   = RANKW'(LINES);

  function automatic logic [RANKW-1:0] rank_of(input logic [LINES-1:0] v,
                                               input logic [RW-1:0] b);
    logic [RANKW-1:0] r;
    r = NO_RANK;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[RW'(i) + b]) r = RANKW'(i);
    return r;
  endfunction

  logic [LINES-1:0] last_q;
  logic [LINES-1:0] pend, isr_eff, cas_mask, rise, take_vec;
  logic [RANKW-1:0] p_rank, c_rank;
  logic [RW-1:0]    win_line;
  logic             win, take;

  assign pend     = irr_q & ~mask;
  assign cas_mask = (IS_MASTER && sfnm) ? (LINES'(1) << CASCADE_LINE) : '0;
  assign isr_eff  = isr_q & ~cas_mask;
  assign p_rank   = rank_of(pend, base_q);
  assign c_rank   = rank_of(isr_eff, base_q);
  assign win      = p_rank < c_rank;
  assign win_line = p_rank[RW-1:0] + base_q;
  assign irq_out  = win;
  assign ack_line = win ? win_line : SPUR_LINE;
  assign take     = ack && win;
  assign take_vec = take ? (LINES'(1) << win_line) : '0;
  assign rise     = req_in & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      last_q <= '0;
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      last_q <= req_in;
      irr_q  <= (trig_level & req_in)
              | (~trig_level & ((irr_q & ~take_vec) | rise));
      isr_q  <= (isr_q & ~isr_clr) | ((take && !auto_eoi) ? take_vec : '0);
      if (take && auto_eoi && rot_on_aeoi)
        base_q <= win_line + 1'b1;
      else if (base_wr)
        base_q <= base_val;
    end
  end

  AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(irr_q & ~trig_level & ~take_vec) & ~irr_q) == '0); // R2
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr_q ^ $past(req_in)) & $past(trig_level)) == '0); // R3
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irr_q[ack_line] && !mask[ack_line])); // R4
  AST_ISR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !auto_eoi) |=> isr_q[$past(ack_line)]); // R7
  AST_AEOI_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && auto_eoi && rot_on_aeoi) |=> base_q == RW'($past(ack_line) + 1'b1)); // R8
  AST_SPUR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out) |=> isr_q == $past(isr_q & ~isr_clr)); // R10
endmodule

// File: tb/tb_irq_rank_resolver.sv
module tb_irq_rank_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0, mask = '0, trig_level = '0, isr_clr = '0;
  logic       base_wr = 1'b0, auto_eoi = 1'b0, rot_on_aeoi = 1'b0, sfnm = 1'b0, ack = 1'b0;
  logic [2:0] base_val = '0;
  logic       irq_out;
  logic [2:0] ack_line, base_q;
  logic [7:0] irr_q, isr_q;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_rank_resolver dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask(mask), .trig_level(trig_level),
    .base_wr(base_wr), .base_val(base_val), .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi),
    .sfnm(sfnm), .isr_clr(isr_clr), .ack(ack), .irq_out(irq_out), .ack_line(ack_line),
    .irr_q(irr_q), .isr_q(isr_q), .base_q(base_q)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_in = '0; mask = '0; trig_level = '0; isr_clr = '0;
    base_wr = 0; base_val = '0; auto_eoi = 0; rot_on_aeoi = 0; sfnm = 0; ack = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_ack();
    ack = 1'b1; settle(); tick(); ack = 1'b0; settle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irr", irr_q, 8'h00);
    chk("R1 isr", isr_q, 8'h00);
    chk("R1 base", {5'd0, base_q}, 8'd0);
    chk("R1 irq", {7'd0, irq_out}, 8'd0);
  endtask

  task automatic t_edge_latch();
    do_reset();
    req_in[3] = 1'b1; tick();
    chk("R2 rise sets", irr_q, 8'h08);
    req_in[3] = 1'b0; tick();
    chk("R2 low keeps", irr_q, 8'h08);
    chk("R4 irq", {7'd0, irq_out}, 8'd1);
    chk("R4 line", {5'd0, ack_line}, 8'd3);
  endtask

  task automatic t_level();
    do_reset();
    trig_level[5] = 1'b1; req_in[5] = 1'b1; tick();
    chk("R3 high", irr_q, 8'h20);
    req_in[5] = 1'b0; tick();
    chk("R3 low", irr_q, 8'h00);
  endtask

  task automatic t_rank();
    do_reset();
    req_in = 8'h42; tick(); req_in = 8'h00; tick();
    chk("R4 base0 winner", {5'd0, ack_line}, 8'd1);
    base_wr = 1; base_val = 3'd4; tick(); base_wr = 0; settle();
    chk("R12 base load", {5'd0, base_q}, 8'd4);
    chk("R4 base4 winner", {5'd0, ack_line}, 8'd6);
    mask[6] = 1'b1; settle();
    chk("R4 masked loses", {5'd0, ack_line}, 8'd1);
    mask = 8'hFF; settle();
    chk("R4 all masked", {7'd0, irq_out}, 8'd0);
  endtask

  task automatic t_nested();
    do_reset();
    req_in[4] = 1; tick(); pulse_ack();
    chk("R7 isr set", isr_q, 8'h10);
    req_in[6] = 1; tick(); settle();
    chk("R5 lower blocked", {7'd0, irq_out}, 8'd0);
    req_in[4] = 0; tick(); req_in[4] = 1; tick();
    chk("R5 equal blocked", {7'd0, irq_out}, 8'd0);
    req_in[2] = 1; tick();
    chk("R5 higher irq", {7'd0, irq_out}, 8'd1);
    chk("R5 higher line", {5'd0, ack_line}, 8'd2);
  endtask

  task automatic t_sfnm();
    do_reset();
    req_in[2] = 1; tick(); pulse_ack();
    req_in[2] = 0; tick(); req_in[2] = 1; tick();
    chk("R6 off blocked", {7'd0, irq_out}, 8'd0);
    sfnm = 1'b1; settle();
    chk("R6 on irq", {7'd0, irq_out}, 8'd1);
    chk("R6 on line", {5'd0, ack_line}, 8'd2);
  endtask

  task automatic t_ack_clear();
    do_reset();
    trig_level[5] = 1'b1; req_in = 8'h28; tick(); req_in[3] = 0; tick();
    pulse_ack();
    chk("R9 edge cleared", irr_q, 8'h20);
    chk("R7 isr line3", isr_q, 8'h08);
    isr_clr = 8'h08; tick(); isr_clr = '0; settle();
    chk("R11 clear", isr_q, 8'h00);
    pulse_ack();
    chk("R9 level stays", irr_q, 8'h20);
    chk("R7 isr line5", isr_q, 8'h20);
  endtask

  task automatic t_aeoi();
    do_reset();
    auto_eoi = 1; req_in = 8'h04; tick(); req_in = 0; tick();
    pulse_ack();
    chk("R8 no isr", isr_q, 8'h00);
    chk("R8 no rotate", {5'd0, base_q}, 8'd0);
    chk("R9 aeoi clears edge", irr_q, 8'h00);
    rot_on_aeoi = 1; req_in = 8'h40; tick(); req_in = 0; tick();
    pulse_ack();
    chk("R8 rotated", {5'd0, base_q}, 8'd7);
    chk("R8 no isr rot", isr_q, 8'h00);
  endtask

  task automatic t_spurious();
    do_reset();
    base_wr = 1; base_val = 3'd3; tick(); base_wr = 0;
    mask[7] = 1; req_in[7] = 1; tick(); req_in[7] = 0; tick();
    ack = 1; settle();
    chk("R10 line7", {5'd0, ack_line}, 8'd7);
    chk("R10 no irq", {7'd0, irq_out}, 8'd0);
    tick(); ack = 0; settle();
    chk("R10 isr", isr_q, 8'h00);
    chk("R10 irr kept", irr_q, 8'h80);
    chk("R10 base", {5'd0, base_q}, 8'd3);
  endtask

  task automatic t_set_vs_clear();
    do_reset();
    req_in[1] = 1; tick(); pulse_ack(); req_in[1] = 0;
    req_in[0] = 1; tick();
    ack = 1; isr_clr = 8'h03; tick(); ack = 0; isr_clr = '0; settle();
    chk("R11 set wins", isr_q, 8'h01);
  endtask

  task automatic t_rot_vs_load();
    do_reset();
    auto_eoi = 1; rot_on_aeoi = 1;
    req_in[4] = 1; tick();
    ack = 1; base_wr = 1; base_val = 3'd2; tick(); ack = 0; base_wr = 0; settle();
    chk("R12 rotation wins", {5'd0, base_q}, 8'd5);
  endtask

  task automatic t_edge_vs_ack();
    do_reset();
    req_in[6] = 1; tick(); req_in[6] = 0; tick();
    req_in[6] = 1; ack = 1; tick(); ack = 0; settle();
    chk("R13 irr kept", irr_q, 8'h40);
    chk("R13 isr set", isr_q, 8'h40);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_edge_latch();
    t_level();
    t_rank();
    t_nested();
    t_sfnm();
    t_ack_clear();
    t_aeoi();
    t_spurious();
    t_set_vs_clear();
    t_rot_vs_load();
    t_edge_vs_ack();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule